// File: doc/BRIEF.md
# Receive Descriptor Write-Back Unit

This block sits between a receive MAC byte stream and host memory. A received frame, CRC bytes included, arrives one byte per cycle. The block cuts the frame into pieces that each fit one host receive buffer. Each byte comes out with the memory byte address it belongs at. When a buffer fills, or the frame ends, the block emits a 128-bit write-back descriptor for that buffer.

Two size registers set the buffer size. The per-queue value is used when it is nonzero. When it is zero, the global value is used instead.

The buffer base address comes from the descriptor the host fetched. It is read through `buf_addr` in the cycle that `addr_take` is high, and it may have any byte alignment. Per-frame metadata is read together with the first byte of the frame: the checksum, the error byte and the VLAN tag. The checksum is reported only in the first descriptor of a packet.

Top module: `rx_desc_wb`

## Requirements
- R1: The effective buffer size in bytes is `q_bsize` when that value is nonzero, and `g_bsize` otherwise. Both size inputs and `q_dtype` are sampled at a frame's first byte and held for the rest of that frame.
- R2: Each buffer receives the next min(remaining, size) bytes of the frame. The descriptor length counts exactly the bytes placed in that buffer, CRC bytes included.
- R3: A frame whose length is an exact multiple of the buffer size produces no extra empty descriptor.
- R4: The descriptor's upper 64-bit half is laid out as: bits 79:64 length, bits 95:80 checksum, bits 103:96 status, bits 111:104 errors, bits 127:112 VLAN tag.
- R5: Descriptor bits 63:0 and `wb_addr` hold the buffer base address taken from `buf_addr` when `addr_take` was high. Each byte is written at base plus its offset inside the buffer, for any alignment.
- R6: The checksum field carries the frame's checksum in the first descriptor of a packet and is zero in every later descriptor of the same packet.
- R7: Status bit 0 (done) is set in every descriptor. Status bit 1 (end of packet) is set only in the descriptor holding the frame's last byte.
- R8: When the descriptor type sampled at a frame's first byte is not 3'b000, the frame yields no byte writes, no descriptors and no `addr_take`.
- R9: After reset, `wr_valid` and `wb_valid` are low.
- R10: `wr_*` and `wb_*` appear one clock after the byte that causes them. `addr_take` is combinational with the accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_csum | input | 16 | Frame checksum, read at the first byte |
| in_err | input | 8 | Frame error flags, read at the first byte |
| in_vlan | input | 16 | VLAN tag, read at the first byte |
| q_bsize | input | 16 | Per-queue buffer size in bytes (0 selects the global size) |
| g_bsize | input | 16 | Global buffer size in bytes |
| q_dtype | input | 3 | Per-queue descriptor type; 3'b000 selects the legacy format |
| buf_addr | input | AW | Base address from the fetched descriptor |
| addr_take | output | 1 | `buf_addr` is consumed this cycle |
| wr_valid | output | 1 | A byte write to a buffer is issued |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| wb_valid | output | 1 | A write-back descriptor is issued |
| wb_addr | output | AW | Base address of the buffer just closed |
| wb_len | output | 16 | Byte count placed in that buffer |
| wb_desc | output | 128 | Write-back descriptor |

## Verification
The bench sweeps frame lengths from 1 to 9 bytes against per-queue sizes of 0, 1, 3 and 4 and global sizes of 2 and 5. This mix covers frames shorter than a buffer, exact multiples of the size, and frames with a partial tail, which separates a correct cut from an off-by-one or a spurious empty descriptor. Each buffer gets a differently misaligned base. A garbage value is placed on `buf_addr` whenever no address should be taken, which exposes an unheld base or a wrong write offset. The metadata and size inputs are changed after the first byte to show they are latched at frame start. A frame with a non-legacy type is followed by a legacy frame to show the frame is suppressed and the unit recovers.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int LEN_W  = 16;
  localparam int DESC_W = 128;
  localparam int ST_DD  = 0;
  localparam int ST_EOP = 1;
  localparam logic [2:0] DTYPE_LEGACY = 3'b000;

  // Per-queue size wins unless it is zero.
  function automatic logic [LEN_W-1:0] pick_size(input logic [LEN_W-1:0] q,
                                                 input logic [LEN_W-1:0] g);
    return (q != '0) ? q : g;
  endfunction

  function automatic logic [DESC_W-1:0] pack_legacy(input logic [63:0]      addr,
                                                    input logic [LEN_W-1:0] len,
                                                    input logic [15:0]      csum,
                                                    input logic [7:0]       status,
                                                    input logic [7:0]       errs,
                                                    input logic [15:0]      vlan);
    return {vlan, errs, status, csum, len, addr};
  endfunction
endpackage

// File: rtl/rxwb_size_sel.sv
module rxwb_size_sel
  import rxwb_pkg::*;
(
  input  logic [LEN_W-1:0] q_size,
  input  logic [LEN_W-1:0] g_size,
  output logic [LEN_W-1:0] eff_size
);
  assign eff_size = pick_size(q_size, g_size);
endmodule

// File: rtl/rxwb_seg.sv
module rxwb_seg
  import rxwb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             last,
  input  logic [LEN_W-1:0] sel_size,
  output logic [LEN_W-1:0] offset,
  output logic [LEN_W-1:0] seg_len,
  output logic             frame_start,
  output logic             buf_first,
  output logic             seg_close,
  output logic             pkt_first,
  output logic             frame_open
);
  logic             open_r;
  logic             first_r;
  logic [LEN_W-1:0] cnt_r;
  logic [LEN_W-1:0] size_r;
  logic [LEN_W:0]   nxt;
  logic [LEN_W-1:0] size_now;

  assign frame_start = !open_r;
  assign size_now    = frame_start ? sel_size : size_r;
  assign nxt         = {1'b0, cnt_r} + 1'b1;
  assign buf_first   = (cnt_r == '0);
  assign seg_close   = acc && (last || (nxt == {1'b0, size_now}));
  assign pkt_first   = frame_start || first_r;
  assign offset      = cnt_r;
  assign seg_len     = nxt[LEN_W-1:0];
  assign frame_open  = open_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_r  <= 1'b0;
      first_r <= 1'b0;
      cnt_r   <= '0;
      size_r  <= '0;
    end else if (acc) begin
      open_r  <= !last;
      cnt_r   <= seg_close ? '0 : nxt[LEN_W-1:0];
      first_r <= pkt_first && !seg_close;
      if (frame_start) size_r <= sel_size;
    end
  end
endmodule

// File: rtl/rxwb_desc_fmt.sv
module rxwb_desc_fmt
  import rxwb_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [AW-1:0]     addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [15:0]       csum,
  input  logic              first,
  input  logic              eop,
  input  logic [7:0]        errs,
  input  logic [15:0]       vlan,
  output logic [DESC_W-1:0] desc
);
  logic [7:0]  status;
  logic [15:0] csum_f;

  always_comb begin
    status         = '0;
    status[ST_DD]  = 1'b1;
    status[ST_EOP] = eop;
    csum_f         = first ? csum : 16'h0000;
    desc           = pack_legacy(64'(addr), len, csum_f, status, errs, vlan);
  end
endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
  import rxwb_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [15:0]       in_csum,
  input  logic [7:0]        in_err,
  input  logic [15:0]       in_vlan,
  input  logic [LEN_W-1:0]  q_bsize,
  input  logic [LEN_W-1:0]  g_bsize,
  input  logic [2:0]        q_dtype,
  input  logic [AW-1:0]     buf_addr,
  output logic              addr_take,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [7:0]        wr_data,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_addr,
  output logic [LEN_W-1:0]  wb_len,
  output logic [DESC_W-1:0] wb_desc
);
  logic [LEN_W-1:0]  eff_size;
  logic [LEN_W-1:0]  offset;
  logic [LEN_W-1:0]  seg_len;
  logic              frame_start;
  logic              buf_first;
  logic              seg_close;
  logic              pkt_first;
  logic              frame_open;

  logic              legacy_r;
  logic [AW-1:0]     base_r;
  logic [15:0]       csum_r;
  logic [7:0]        err_r;
  logic [15:0]       vlan_r;

  logic              legacy_now;
  logic [AW-1:0]     addr_now;
  logic [15:0]       csum_now;
  logic [7:0]        err_now;
  logic [15:0]       vlan_now;
  logic [DESC_W-1:0] desc_now;

  rxwb_size_sel u_size (
    .q_size  (q_bsize),
    .g_size  (g_bsize),
    .eff_size(eff_size)
  );

  rxwb_seg u_seg (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (in_valid),
    .last       (in_last),
    .sel_size   (eff_size),
    .offset     (offset),
    .seg_len    (seg_len),
    .frame_start(frame_start),
    .buf_first  (buf_first),
    .seg_close  (seg_close),
    .pkt_first  (pkt_first),
    .frame_open (frame_open)
  );

  assign legacy_now = frame_start ? (q_dtype == DTYPE_LEGACY) : legacy_r;
  assign addr_now   = buf_first ? buf_addr : base_r;
  assign csum_now   = frame_start ? in_csum : csum_r;
  assign err_now    = frame_start ? in_err  : err_r;
  assign vlan_now   = frame_start ? in_vlan : vlan_r;
  assign addr_take  = in_valid && legacy_now && buf_first;

  rxwb_desc_fmt #(.AW(AW)) u_fmt (
    .addr (addr_now),
    .len  (seg_len),
    .csum (csum_now),
    .first(pkt_first),
    .eop  (in_last),
    .errs (err_now),
    .vlan (vlan_now),
    .desc (desc_now)
  );

  // Per-frame context
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_r <= 1'b0;
      base_r   <= '0;
      csum_r   <= '0;
      err_r    <= '0;
      vlan_r   <= '0;
    end else if (in_valid) begin
      base_r <= addr_now;
      if (frame_start) begin
        legacy_r <= legacy_now;
        csum_r   <= in_csum;
        err_r    <= in_err;
        vlan_r   <= in_vlan;
      end
    end
  end

  // Registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_len   <= '0;
      wb_desc  <= '0;
    end else begin
      wr_valid <= in_valid && legacy_now;
      wb_valid <= seg_close && legacy_now;
      if (in_valid) begin
        wr_addr <= addr_now + AW'(offset);
        wr_data <= in_data;
      end
      if (seg_close) begin
        wb_addr <= addr_now;
        wb_len  <= seg_len;
        wb_desc <= desc_now;
      end
    end
  end
endmodule

// File: rtl/rxwb_chk.sv
module rxwb_chk
  import rxwb_pkg::*;
#(
  parameter int AW = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_last,
  input logic [2:0]        q_dtype,
  input logic              frame_open,
  input logic              wr_valid,
  input logic              wb_valid,
  input logic [AW-1:0]     wb_addr,
  input logic [LEN_W-1:0]  wb_len,
  input logic [DESC_W-1:0] wb_desc
);
  // R2
  wb_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_len != '0));
  // R2
  wb_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wr_valid);
  // R4
  len_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_desc[79:64] == wb_len));
  // R5
  addr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_desc[63:0] == 64'(wb_addr)));
  // R7
  done_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_desc[96]);
  // R7
  eop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_desc[97]) |-> $past(in_valid && in_last));
  // R8
  non_legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !frame_open && (q_dtype != DTYPE_LEGACY)) |=> (!wr_valid && !wb_valid));
endmodule

bind rx_desc_wb rxwb_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .q_dtype   (q_dtype),
  .frame_open(frame_open),
  .wr_valid  (wr_valid),
  .wb_valid  (wb_valid),
  .wb_addr   (wb_addr),
  .wb_len    (wb_len),
  .wb_desc   (wb_desc)
);

// File: tb/rx_desc_wb_tb.sv
`timescale 1ns/1ps
module rx_desc_wb_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_last = 1'b0;
  logic [15:0]  in_csum = '0;
  logic [7:0]   in_err = '0;
  logic [15:0]  in_vlan = '0;
  logic [15:0]  q_bsize = '0;
  logic [15:0]  g_bsize = 16'd2;
  logic [2:0]   q_dtype = 3'b000;
  logic [63:0]  buf_addr = '0;
  logic         addr_take;
  logic         wr_valid;
  logic [63:0]  wr_addr;
  logic [7:0]   wr_data;
  logic         wb_valid;
  logic [63:0]  wb_addr;
  logic [15:0]  wb_len;
  logic [127:0] wb_desc;

  int vecs  = 0;
  int fails = 0;
  int fid   = 0;

  always #2 clk = ~clk;

  rx_desc_wb #(.AW(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_csum(in_csum), .in_err(in_err), .in_vlan(in_vlan),
    .q_bsize(q_bsize), .g_bsize(g_bsize), .q_dtype(q_dtype), .buf_addr(buf_addr),
    .addr_take(addr_take), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_len(wb_len), .wb_desc(wb_desc)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] base_of(input int f, input int k);
    return 64'h1000_0000 + 64'(k) * 64'h100 + 64'((f + 3 * k) % 16);
  endfunction

  // Sends one frame and checks every output cycle; legacy=0 expects silence.
  task automatic send_frame(input int qs, input int gs, input int len, input bit legacy);
    int eff;
    logic [15:0] cs;
    logic [7:0]  er;
    logic [15:0] vl;
    eff = (qs != 0) ? qs : gs;
    cs = 16'hA000 + 16'(fid);
    er = 8'h10 + 8'(fid);
    vl = 16'h0E00 + 16'(fid);
    q_bsize = 16'(qs);
    g_bsize = 16'(gs);
    q_dtype = legacy ? 3'b000 : 3'b001;
    for (int i = 0; i < len; i++) begin
      int k;
      int off;
      bit close;
      bit last;
      logic [63:0]  ba;
      logic [127:0] ed;
      logic [7:0]   st;
      k = i / eff;
      off = i % eff;
      last = (i == len - 1);
      close = last || (off == eff - 1);
      ba = base_of(fid, k);
      in_valid = 1'b1;
      in_data  = 8'(fid * 16 + i);
      in_last  = last;
      buf_addr = (off == 0) ? ba : 64'hDEAD_BEEF;
      in_csum  = (i == 0) ? cs : ~cs;
      in_err   = (i == 0) ? er : ~er;
      in_vlan  = (i == 0) ? vl : ~vl;
      if (i == 1) begin
        // R1: changes after the first byte must not matter
        q_bsize = 16'd7;
        g_bsize = 16'd9;
        q_dtype = legacy ? 3'b010 : 3'b000;
      end
      #1;
      // R10 R5: combinational address consumption
      chk(addr_take == (legacy && off == 0), "R10 addr_take", 128'(addr_take),
          128'(legacy && off == 0));
      @(negedge clk);
      if (legacy) begin
        chk(wr_valid && wr_addr == ba + 64'(off) && wr_data == 8'(fid * 16 + i),
            "R5 byte write", {wr_valid, wr_addr, wr_data}, {1'b1, ba + 64'(off), 8'(fid * 16 + i)});
        // R2 R3: descriptor closes exactly at size boundary or frame end
        chk(wb_valid == close, "R3 wb_valid", 128'(wb_valid), 128'(close));
        if (close && wb_valid) begin
          st = 8'h01 | (last ? 8'h02 : 8'h00);
          ed = {vl, er, st, (k == 0) ? cs : 16'h0000, 16'(off + 1), ba};
          chk(wb_len == 16'(off + 1), "R2 wb_len", 128'(wb_len), 128'(off + 1));
          chk(wb_addr == ba, "R5 wb_addr", 128'(wb_addr), 128'(ba));
          // R4 R6 R7: full descriptor image
          chk(wb_desc == ed, "R4 R6 R7 descriptor", wb_desc, ed);
        end
      end else begin
        // R8
        chk(!wr_valid && !wb_valid, "R8 suppressed", {wr_valid, wb_valid}, 128'(0));
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(negedge clk);
    chk(!wr_valid && !wb_valid, "R10 idle after frame", {wr_valid, wb_valid}, 128'(0));
    fid++;
  endtask

  initial begin
    int qs_tab [4] = '{0, 1, 3, 4};
    int gs_tab [2] = '{2, 5};
    repeat (3) @(negedge clk);
    // R9
    chk(!wr_valid && !wb_valid, "R9 reset", {wr_valid, wb_valid}, 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid && !wb_valid, "R9 after reset", {wr_valid, wb_valid}, 128'(0));
    for (int qi = 0; qi < 4; qi++)
      for (int gi = 0; gi < 2; gi++)
        for (int len = 1; len <= 9; len++)
          send_frame(qs_tab[qi], gs_tab[gi], len, 1'b1);
    // R8: non-legacy frames, then legacy frames to show recovery
    send_frame(0, 2, 5, 1'b0);
    send_frame(3, 5, 1, 1'b0);
    send_frame(3, 5, 7, 1'b1);
    send_frame(0, 4, 8, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule